// File: doc/BRIEF.md
# Input Adapter Qualification Sequencer

This block decides whether a freshly attached input supply is strong enough to power charging. Each power-on-reset strobe starts a qualification run: the block turns on an external load current sink and watches a comparator flag that reports whether the input stays above its minimum level. If the flag stays high for a whole qualification window, the sink is released and an "adapter good" flag lets downstream charging logic start.

If the flag drops at any sampled cycle of the window, the sink is released at once, the supply is declared bad, a fixed fault code is posted and a fault pulse is requested. After a hold-off delay, the block tries again. The retries have no limit. All delays are counted in clock cycles and set by parameters. The comparator and the sink are outside the block and appear as plain digital signals.

Top module: `adp_qual_seq`

## Requirements
- R1: After reset, `sink_en`, `adp_good` and `fault_pulse` are 0 and `fault_code` is 3'b000. The block stays idle, ignoring `vin_ok`, until the first `por_evt`.
- R2: A cycle in which `por_evt` is 1 makes `sink_en` 1 from the next cycle, which starts a qualification window.
- R3: If `vin_ok` is sampled 1 on QUAL_CYC consecutive cycles of the window, then from the following cycle `sink_en` is 0 and `adp_good` is 1. `adp_good` then holds until the next `por_evt`.
- R4: If `vin_ok` is sampled 0 on any cycle of the window, including the last one, then `sink_en` is 0 from the next cycle and `adp_good` stays 0.
- R5: A rejection sets `fault_code` to 3'b011 (bad input source) from the next cycle. It also drives `fault_pulse` high for exactly PULSE_CYC cycles, starting in that same cycle.
- R6: After a rejection, `sink_en` stays 0 for exactly HOLD_CYC cycles, and then a new window starts. This repeats with no limit on the number of retries.
- R7: `por_evt` takes priority over every other condition, in every state. It restarts the window from its first cycle, drops `adp_good`, and overrides a low `vin_ok` sampled in the same cycle.
- R8: `fault_code` returns to 3'b000 in the same cycle that `adp_good` rises. Otherwise it holds its value, and a `por_evt` does not clear it.
- R9: `adp_good` and `sink_en` are never 1 together. Changes on `vin_ok` outside a window have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_evt | input | 1 | Input power-on-reset strobe; restarts qualification |
| vin_ok | input | 1 | Comparator flag: the input is above its minimum level |
| sink_en | output | 1 | Enable for the external load current sink |
| adp_good | output | 1 | Registered flag: the supply is accepted |
| fault_code | output | 3 | 3'b000 = none, 3'b011 = bad input source |
| fault_pulse | output | 1 | Fault pulse request, PULSE_CYC cycles long |

## Verification
The hardest cases to reach are those where two conditions meet on the same edge. One is a dip sampled on the very last cycle of the window, which must still reject. Another is a strobe arriving together with a low flag, or in the middle of a hold-off. The stimulus counts cycles from each strobe to place a dip exactly on the final window cycle and a strobe inside a hold-off. A reference model that counts down the remaining window, hold-off and pulse cycles is compared with every output on every clock.

// File: rtl/adp_qual_pkg.sv
package adp_qual_pkg;

   typedef enum logic [1:0] {
      AQ_IDLE = 2'd0,
      AQ_QUAL = 2'd1,
      AQ_HOLD = 2'd2,
      AQ_GOOD = 2'd3
   } aq_state_e;

   localparam logic [2:0] AQ_CODE_NONE = 3'b000;
   localparam logic [2:0] AQ_CODE_BAD  = 3'b011;

   function automatic int unsigned aq_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adp_qual_timer.sv
module adp_qual_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/adp_qual_pulse.sv
module adp_qual_pulse #(
   parameter int unsigned PULSE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic pulse_o
);

   generate
      if (PULSE_CYC < 1) begin : g_bad_len
         $error("adp_qual_pulse: PULSE_CYC must be at least 1");
      end

      if (PULSE_CYC == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= start;
         end
         assign pulse_o = q;
      end else begin : g_count
         localparam int unsigned PW = $clog2(PULSE_CYC + 1);
         localparam logic [PW-1:0] P_LOAD = PW'(PULSE_CYC);
         logic [PW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          left <= '0;
            else if (start)      left <= P_LOAD;
            else if (left != '0) left <= left - 1'b1;
         end
         assign pulse_o = (left != '0);
      end
   endgenerate

   AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> pulse_o); // R5

endmodule

// File: rtl/adp_qual_fsm.sv
module adp_qual_fsm
   import adp_qual_pkg::*;
#(
   parameter int unsigned QUAL_CYC = 16,
   parameter int unsigned HOLD_CYC = 16,
   parameter int unsigned CW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          por_evt,
   input  logic          vin_ok,
   input  logic [CW-1:0] cnt,
   output logic          cnt_clr,
   output logic          cnt_en,
   output logic          reject,
   output logic          sink_en_q,
   output logic          good_q,
   output logic [2:0]    code_q
);

   localparam logic [CW-1:0] Q_LAST = CW'(QUAL_CYC - 1);
   localparam logic [CW-1:0] H_LAST = CW'(HOLD_CYC - 1);

   aq_state_e state_q, state_d;
   logic      pass;

   always_comb begin
      state_d = state_q;
      cnt_clr = 1'b0;
      reject  = 1'b0;
      pass    = 1'b0;
      if (por_evt) begin
         state_d = AQ_QUAL;
         cnt_clr = 1'b1;
      end else begin
         unique case (state_q)
            AQ_QUAL: begin
               if (!vin_ok) begin
                  state_d = AQ_HOLD;
                  cnt_clr = 1'b1;
                  reject  = 1'b1;
               end else if (cnt == Q_LAST) begin
                  state_d = AQ_GOOD;
                  cnt_clr = 1'b1;
                  pass    = 1'b1;
               end
            end
            AQ_HOLD: begin
               if (cnt == H_LAST) begin
                  state_d = AQ_QUAL;
                  cnt_clr = 1'b1;
               end
            end
            default: state_d = state_q;
         endcase
      end
   end

   assign cnt_en = (state_q == AQ_QUAL) || (state_q == AQ_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= AQ_IDLE;
         sink_en_q <= 1'b0;
         good_q    <= 1'b0;
         code_q    <= AQ_CODE_NONE;
      end else begin
         state_q   <= state_d;
         sink_en_q <= (state_d == AQ_QUAL);
         good_q    <= (state_d == AQ_GOOD);
         if (reject)    code_q <= AQ_CODE_BAD;
         else if (pass) code_q <= AQ_CODE_NONE;
      end
   end

   AST_POR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      por_evt |=> (sink_en_q && !good_q)); // R7

   AST_DIP_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (sink_en_q && !vin_ok && !por_evt) |=> (!sink_en_q && !good_q && code_q == AQ_CODE_BAD)); // R4

   AST_GOOD_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(good_q) |-> $past(sink_en_q)); // R3

   AST_GOOD_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      good_q |-> (code_q == AQ_CODE_NONE)); // R8

   AST_SINK_GOOD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sink_en_q && good_q)); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == AQ_QUAL) |-> (cnt <= Q_LAST)); // R3

   AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == AQ_HOLD) |-> (cnt <= H_LAST)); // R6

endmodule

// File: rtl/adp_qual_seq.sv
module adp_qual_seq
   import adp_qual_pkg::*;
#(
   parameter int unsigned QUAL_CYC  = 30000,
   parameter int unsigned HOLD_CYC  = 100000,
   parameter int unsigned PULSE_CYC = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_evt,
   input  logic       vin_ok,
   output logic       sink_en,
   output logic       adp_good,
   output logic [2:0] fault_code,
   output logic       fault_pulse
);

   localparam int unsigned MAXC = aq_max(QUAL_CYC, HOLD_CYC);
   localparam int unsigned CW   = $clog2(MAXC);

   generate
      if (QUAL_CYC < 2) begin : g_bad_qual
         $error("adp_qual_seq: QUAL_CYC must be at least 2");
      end
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("adp_qual_seq: HOLD_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          cnt_clr;
   logic          cnt_en;
   logic          reject;

   adp_qual_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (cnt_en),
      .cnt   (cnt)
   );

   adp_qual_fsm #(
      .QUAL_CYC (QUAL_CYC),
      .HOLD_CYC (HOLD_CYC),
      .CW       (CW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_evt   (por_evt),
      .vin_ok    (vin_ok),
      .cnt       (cnt),
      .cnt_clr   (cnt_clr),
      .cnt_en    (cnt_en),
      .reject    (reject),
      .sink_en_q (sink_en),
      .good_q    (adp_good),
      .code_q    (fault_code)
   );

   adp_qual_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (reject),
      .pulse_o (fault_pulse)
   );

   AST_REJECT_PULSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_pulse) |-> (fault_code == AQ_CODE_BAD)); // R5

endmodule

// File: tb/tb_adp_qual_seq.sv
`timescale 1ns/1ps
module tb_adp_qual_seq;

   localparam int QC = 12;
   localparam int HC = 7;
   localparam int PC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_evt = 1'b0;
   logic       vin_ok = 1'b0;
   logic       sink_en, adp_good, fault_pulse;
   logic [2:0] fault_code;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   adp_qual_seq #(.QUAL_CYC(QC), .HOLD_CYC(HC), .PULSE_CYC(PC)) dut (
      .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .vin_ok(vin_ok),
      .sink_en(sink_en), .adp_good(adp_good),
      .fault_code(fault_code), .fault_pulse(fault_pulse)
   );

   // Behavioural reference: 0 idle, 1 window, 2 hold-off, 3 accepted
   int m_st = 0, m_qleft = 0, m_hleft = 0, m_pleft = 0, m_code = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_qleft = 0; m_hleft = 0; m_pleft = 0; m_code = 0;
      end else begin
         if (m_pleft > 0) m_pleft = m_pleft - 1;
         if (por_evt) begin
            m_st = 1; m_qleft = QC;
         end else if (m_st == 1) begin
            if (!vin_ok) begin
               m_st = 2; m_hleft = HC; m_code = 3; m_pleft = PC;
            end else begin
               m_qleft = m_qleft - 1;
               if (m_qleft == 0) begin m_st = 3; m_code = 0; end
            end
         end else if (m_st == 2) begin
            m_hleft = m_hleft - 1;
            if (m_hleft == 0) begin m_st = 1; m_qleft = QC; end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(sink_en == (m_st == 1), "R2/R4/R6 sink_en", sink_en, m_st == 1);
         chk(adp_good == (m_st == 3), "R3/R9 adp_good", adp_good, m_st == 3);
         chk(int'(fault_code) == m_code, "R5/R8 fault_code", fault_code, m_code);
         chk(fault_pulse == (m_pleft > 0), "R5 fault_pulse", fault_pulse, m_pleft > 0);
      end
   end

   task automatic tick(input bit p, input bit v);
      @(negedge clk);
      por_evt = p;
      vin_ok  = v;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         total++; fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run finished)");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      int zeros, highs;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(!sink_en && !adp_good && !fault_pulse, "R1 outputs low in reset", sink_en|adp_good|fault_pulse, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) tick(0, i[0]);
      tick(0, 0);
      chk(!sink_en && !adp_good, "R1 idle without strobe", sink_en|adp_good, 0);
      chk(fault_code == 3'b000, "R1 fault_code reset", fault_code, 0);

      // R2/R3: clean pass
      tick(1, 1);
      tick(0, 1);
      chk(sink_en == 1'b1, "R2 sink on after strobe", sink_en, 1);
      for (int i = 0; i < QC; i++) tick(0, 1);
      chk(adp_good == 1'b1 && sink_en == 1'b0, "R3 accepted after window", adp_good, 1);
      chk(fault_code == 3'b000, "R8 code after pass", fault_code, 0);

      // R9: flag activity while accepted has no effect
      for (int i = 0; i < 5; i++) tick(0, i[0]);
      tick(0, 1);
      chk(adp_good == 1'b1 && !sink_en && !fault_pulse, "R9 accepted ignores vin_ok", adp_good, 1);

      // R7: strobe while accepted
      tick(1, 1);
      tick(0, 1);
      chk(!adp_good && sink_en, "R7 strobe drops good", adp_good, 0);

      // R4/R5/R6: dip, hold-off, pulse length
      for (int i = 0; i < 3; i++) tick(0, 1);
      tick(0, 0);
      tick(0, 1);
      chk(!sink_en && !adp_good, "R4 sink off after dip", sink_en, 0);
      chk(fault_code == 3'b011, "R5 bad code", fault_code, 3);
      zeros = 0; highs = 0;
      for (int i = 0; i < HC + 5 && !sink_en; i++) begin
         zeros++;
         if (fault_pulse) highs++;
         tick(0, 1);
      end
      chk(zeros == HC, "R6 hold-off length", zeros, HC);
      chk(highs == PC, "R5 pulse length", highs, PC);

      // R6: second retry rejected, third passes, R8 code cleared
      tick(0, 0);
      tick(0, 1);
      chk(!sink_en && fault_code == 3'b011, "R6 repeated rejection", sink_en, 0);
      for (int i = 0; i < HC + QC + 2; i++) tick(0, 1);
      chk(adp_good && fault_code == 3'b000, "R8 code cleared on retry pass", fault_code, 0);

      // R4 boundary: dip on final window cycle
      tick(1, 1);
      for (int i = 0; i < QC - 1; i++) tick(0, 1);
      tick(0, 0);
      tick(0, 1);
      chk(!adp_good && !sink_en && fault_code == 3'b011, "R4 dip on last window cycle", adp_good, 0);

      // R7: strobe during hold-off, then strobe with low flag
      tick(0, 1);
      tick(1, 0);
      tick(0, 1);
      chk(sink_en == 1'b1, "R7 strobe in hold-off restarts", sink_en, 1);
      tick(1, 0);
      tick(0, 1);
      chk(sink_en == 1'b1 && fault_code == 3'b011, "R7 strobe beats low flag", sink_en, 1);
      for (int i = 0; i < QC + 2; i++) tick(0, 1);
      chk(adp_good == 1'b1, "R3 pass after restart", adp_good, 1);

      tick(0, 1);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule